// File: doc/BRIEF.md
# Random Word Register Pair

This block puts a pseudo-random source behind two 32-bit registers on a simple register bus. The bus uses word addresses and has a write strobe, a read strobe, write data and read data. Software enables or disables the generator through a control register and reads random words from a data register. A 32-bit Galois linear feedback shift register (LFSR) supplies the words. It is a stand-in for a real entropy source.

Read data is combinational. It is valid in the same cycle as the read strobe and reflects the state before that cycle's clock edge. Every value that is consumed moves the generator one step. A value is consumed by a data read while enabled, or by a control write that leaves the generator enabled. While the generator is disabled, the data register holds zero and the LFSR state is frozen. Re-enabling the generator therefore continues the same sequence. The bus carries single register accesses with no back-pressure, so it has no valid/ready pair. Every access completes in the cycle it is presented.

Top module: `rand_word_regs`

## Requirements
- R1: After reset, the control register reads 0x80000000 and the data register reads the seed 0x1D872B41.
- R2: The control register is at word address 0x3C (byte offset 0xF0). The data register is at word address 0x3D (byte offset 0xF4).
- R3: A control write stores only the bits selected by mask 0x2F, which are bits 0–3 and bit 5. Control read bits 30:4 other than bit 5 are always zero, whatever was written.
- R4: Control bit 31 is a read-only valid flag. It reads 1 when disable bit 0 is 0 and reads 0 otherwise. Writing bit 31 has no effect.
- R5: A control write with bit 0 set makes the data register read 0 from the next cycle on.
- R6: A control write with bit 0 clear advances the LFSR one step and loads the new state into the data register. The LFSR step is next = (s >> 1) ^ (s[0] ? 0x80200003 : 0).
- R7: A data read while enabled returns the held word, then advances the LFSR one step and loads the new state into the data register. Consecutive reads therefore differ.
- R8: A data read while disabled returns 0 and does not advance the LFSR. A later enabling write yields the step after the last state produced before the disable.
- R9: Reads of any other word address return 0. Writes to any address other than control, including the data register, change nothing.
- R10: With read and write strobes in the same cycle, the read data shows the state from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_rd is low |

## Verification
The bench sweeps every word address with reads and writes. A decoder that aliases upper address bits would return nonzero data or corrupt the control register, and the sweep would catch both. It writes all 64 patterns of the low six control bits with the upper bits forced high. This catches a wrong mask or a writable valid flag: either would show up in the control readback, or as data that fails to go to zero or to resume. The bench tracks the LFSR sequence arithmetically across disable and enable cycles. A design that advanced while disabled, skipped the step on enable, or reset the sequence would return the wrong word. A same-cycle read and write of control shows whether the read data leaks the value being written.

// File: rtl/rand_regs_pkg.sv
package rand_regs_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned CTRL_BITS    = 6;
  localparam logic [11:0] CTRL_BYTE_OFS = 12'hF0;
  localparam logic [11:0] DATA_BYTE_OFS = 12'hF4;
  localparam logic [CTRL_BITS-1:0] CTRL_WR_MASK = 6'h2F;
  localparam int unsigned DIS_POS      = 0;
  localparam logic [REG_W-1:0] LFSR_TAPS = 32'h8020_0003;
  localparam logic [REG_W-1:0] LFSR_SEED = 32'h1D87_2B41;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] state_q;

  always_comb begin
    nxt_o = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= nxt_o;
  end

  // R6/R7: an LFSR must never fall into the all-zero lock state
  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R8: the state is frozen when no value is consumed
  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state_q));
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl #(
  parameter int unsigned NB = 6,
  parameter logic [NB-1:0] MASK = '1,
  parameter int unsigned DIS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NB-1:0] wbits,
  output logic [NB-1:0] bits_o,
  output logic          dis_o
);
  logic [NB-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     bits_q <= '0;
    else if (wr_en) bits_q <= wbits & MASK;
  end

  assign bits_o = bits_q;
  assign dis_o  = bits_q[DIS];

  // R3: a control write lands masked on the next cycle
  assert_ctrl_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bits_q == ($past(wbits) & MASK));
  // R9: without a control write the stored bits stay put
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q));
endmodule

// File: rtl/rng_data.sv
module rng_data #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    data_q <= SEED;
    else if (clr)  data_q <= '0;
    else if (load) data_q <= val;
  end

  assign data_o = data_q;

  // R5: a clear leaves zero behind
  assert_data_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> data_q == '0);
endmodule

// File: rtl/rand_word_regs.sv
module rand_word_regs
  import rand_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_WA = ADDR_W'(CTRL_BYTE_OFS >> 2);
  localparam logic [ADDR_W-1:0] DATA_WA = ADDR_W'(DATA_BYTE_OFS >> 2);
  localparam int unsigned PAD_W = REG_W - 1 - CTRL_BITS;

  logic                 hit_ctrl, hit_data;
  logic                 ctrl_wr, data_rd, dis, consume, clr;
  logic [CTRL_BITS-1:0] ctrl_bits;
  logic [REG_W-1:0]     lfsr_nxt, data_q, ctrl_view;

  assign hit_ctrl = (bus_addr == CTRL_WA);
  assign hit_data = (bus_addr == DATA_WA);
  assign ctrl_wr  = bus_wr && hit_ctrl;
  assign data_rd  = bus_rd && hit_data;
  assign clr      = ctrl_wr && bus_wdata[DIS_POS];
  assign consume  = (ctrl_wr && !bus_wdata[DIS_POS]) || (data_rd && !dis);

  rng_ctrl #(.NB(CTRL_BITS), .MASK(CTRL_WR_MASK), .DIS(DIS_POS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
    .wbits(bus_wdata[CTRL_BITS-1:0]), .bits_o(ctrl_bits), .dis_o(dis)
  );

  rng_lfsr #(.W(REG_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(consume), .nxt_o(lfsr_nxt)
  );

  rng_data #(.W(REG_W), .SEED(LFSR_SEED)) u_data (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(consume),
    .val(lfsr_nxt), .data_o(data_q)
  );

  assign ctrl_view = {~dis, {PAD_W{1'b0}}, ctrl_bits};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)      bus_rdata = ctrl_view;
      else if (hit_data) bus_rdata = data_q;
    end
  end

  // R7: an enabled data read yields a different word next time
  assert_read_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !dis && !ctrl_wr) |=> data_q != $past(data_q));
  // R8: disabled and untouched, the data register stays at zero
  assert_disabled_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !ctrl_wr) |=> data_q == '0);
  // R4: the valid flag tracks the stored disable bit on read-back
  assert_valid_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_ctrl) |-> bus_rdata[REG_W-1] == !ctrl_bits[DIS_POS]);
  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_ctrl && !hit_data) |-> bus_rdata == '0);
  // R6: enabling write sets valid and data differs from zero next cycle
  assert_enable_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[DIS_POS]) |=> (!dis && data_q != '0));
endmodule

// File: tb/test_rand_word_regs.sv
module test_rand_word_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_lfsr, m_data;
  logic        m_dis;

  localparam logic [7:0] A_CTRL = 8'h3C;
  localparam logic [7:0] A_DATA = 8'h3D;

  always #4 clk = ~clk;

  rand_word_regs i_rand_word_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #2 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  function automatic logic [31:0] ctrl_exp(input logic [31:0] d);
    return (d & 32'h2F) | (d[0] ? 32'h0 : 32'h8000_0000);
  endfunction

  // model of a control write
  task automatic m_ctrl(input logic [31:0] d);
    m_dis = d[0];
    if (d[0]) m_data = 0;
    else begin m_lfsr = step(m_lfsr); m_data = m_lfsr; end
  endtask

  // read data and compare with model, then advance the model
  task automatic chk_data(input string req);
    logic [31:0] v;
    rd(A_DATA, v);
    chk(req, v, m_data);
    if (!m_dis) begin m_lfsr = step(m_lfsr); m_data = m_lfsr; end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, prev, ctrl_before;
    m_lfsr = 32'h1D87_2B41; m_data = m_lfsr; m_dis = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1, R2: reset state
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h8000_0000);
    chk_data("R1 R2 data reset");

    // R7: consecutive reads differ and follow the sequence
    for (int i = 0; i < 20; i++) begin
      rd(A_DATA, v);
      chk("R7 read sequence", v, m_data);
      if (i > 0 && v == prev) chk("R7 reads differ", v, ~prev);
      prev = v;
      m_lfsr = step(m_lfsr); m_data = m_lfsr;
    end

    // R3, R4, R5, R6, R8: sweep all low control patterns with upper bits high
    for (int p = 0; p < 64; p++) begin
      logic [31:0] d;
      d = 32'hFFFF_FFC0 | 32'(p);
      wr(A_CTRL, d); m_ctrl(d);
      rd(A_CTRL, v); chk("R3 R4 ctrl mask/valid", v, ctrl_exp(d));
      chk_data(d[0] ? "R5 R8 disabled data" : "R6 enabled data");
      chk_data(d[0] ? "R8 disabled stays 0" : "R7 next data");
    end

    // R8: disable, read many, re-enable continues sequence
    wr(A_CTRL, 32'h1); m_ctrl(32'h1);
    for (int i = 0; i < 5; i++) chk_data("R8 disabled read");
    wr(A_CTRL, 32'h0); m_ctrl(32'h0);
    chk_data("R8 resume sequence");

    // R9: data write ignored
    wr(A_DATA, 32'h1234_5678);
    chk_data("R9 data write ignored");

    // R9: address sweep of unmapped reads and writes
    rd(A_CTRL, ctrl_before);
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] != A_CTRL && a[7:0] != A_DATA) begin
        rd(a[7:0], v); chk("R9 unmapped read", v, 32'h0);
        wr(a[7:0], 32'hFFFF_FFFF);
      end
    end
    rd(A_CTRL, v); chk("R9 ctrl unchanged", v, ctrl_before);
    chk_data("R9 data unchanged");

    // R10: same-cycle read and write of control
    @(negedge clk);
    bus_addr = A_CTRL; bus_rd = 1; bus_wr = 1; bus_wdata = 32'h21;
    #2 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0; bus_wr = 0;
    m_ctrl(32'h21);
    chk("R10 read before write", v, 32'h8000_0000);
    rd(A_CTRL, v); chk("R10 write applied", v, 32'h21);
    chk_data("R10 R5 data zero");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule